// File: doc/BRIEF.md
# Programmable Parallel Port Interface

This block gives a processor three parallel ports behind a four-location register window. Ports A and B are 8 bits wide. Port C is 8 bits wide and its two 4-bit halves take their directions separately. A single control location accepts two kinds of write, told apart by bit 7. One is a configuration word that sets port directions and group modes. The other changes one port-C bit without touching the others.

Each of the A and B groups runs either in basic mode or in strobed mode. In basic mode a port is a plain input or a latched output. In strobed mode the port gets a three-wire handshake carried on fixed port-C bits: a latched input with strobe, buffer-full flag and interrupt request, or a latched output with acknowledge, output-buffer-full and interrupt request. Pins come out as separate input, output and output-enable signals, so the pad ring can build the tristate drivers.

Top module: `par_io_hub`

## Requirements
- R1: After reset every port is an input in basic mode (no output enable set), all output latches are zero and a read of the control location (select 3) returns 8'h8F.
- R2: A control write with bit 7 = 1 loads the configuration from bits 5:0 (bit 0 A input, bit 1 B input, bit 2 C upper input, bit 3 C lower input, bit 4 A strobed, bit 5 B strobed; a 1 means input or strobed). It also clears the A, B and C output latches and every handshake flag.
- R3: A port set as output drives its latch on its pins (output enable high) and a read returns the latch. A write to a port set as input updates its latch but leaves its output enable low.
- R4: A read of a basic-mode input port (select 0 = A, 1 = B) returns the pin value present in the cycle of the read, with no latching. Read data appears on the read bus one clock after the read strobe.
- R5: A control write with bit 7 = 0 sets port-C bit number bits 3:1 to the value of bit 0 and leaves the other seven latch bits unchanged.
- R6: The two halves of port C (bits 3:0 and 7:4) take directions independently. A read of port C (select 2) returns the latch for output bits and the pins for input bits.
- R7: In strobed input mode, a high-to-low transition on the strobe bit captures the port pins. In the next cycle the buffer-full flag (active high) and the interrupt are raised. Reads return the captured byte even after the pins change, and a read of the port clears the flag and the interrupt.
- R8: In strobed output mode, the output-buffer-full pin (active low, idle high) goes low and the interrupt falls after a write to the port. A high-to-low transition on the acknowledge bit sends the flag pin high and raises the interrupt.
- R9: Handshake lanes sit on port C: group A uses bit 3 (interrupt), bit 4 (strobe/acknowledge input) and bit 5 (flag); group B uses bits 0, 1 and 2 the same way. The interrupt and flag bits are driven and the strobe bit is not. Bits 6 and 7 stay data lines that follow the upper-half direction.
- R10: A single-bit port-C command leaves the configuration unchanged. A control read returns bit 7 set, bit 6 clear and the configuration in bits 5:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 2 | Register select: 0 A, 1 B, 2 C, 3 control |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 1 | Port A output enable |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 1 | Port B output enable |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C per-bit drive value |
| pc_oe | output | 8 | Port C per-bit output enable |

## Verification
The bench targets input reads whose pin value moves between two reads. A design that latched basic inputs would return the stale byte. In strobed input it changes the pins after the strobe, and a design that read through would return the new value instead of the captured one. It checks that a configuration write clears latches that were set earlier, and that a single-bit command touches exactly one bit. A wrong index decode or a whole-byte write would show up as extra changed bits. It also drives the handshake in both directions and watches the flag polarity and the pin ownership of bits 0 to 7, where a swapped lane would drive the strobe input or release the interrupt pin.

// File: rtl/par_io_pkg.sv
package par_io_pkg;

    localparam int BUS_W    = 8;
    localparam int PORT_W   = 8;
    localparam int C_W      = 8;
    localparam int HALF_W   = C_W / 2;
    localparam int N_GRP    = 2;
    localparam int SEL_W    = 2;
    localparam int IDX_W    = $clog2(C_W);
    localparam int KIND_BIT = BUS_W - 1;

    typedef enum logic [SEL_W-1:0] {
        SEL_A   = 2'd0,
        SEL_B   = 2'd1,
        SEL_C   = 2'd2,
        SEL_CTL = 2'd3
    } reg_sel_e;

    // Configuration word, bit 0 is a_in
    typedef struct packed {
        logic b_strobed;
        logic a_strobed;
        logic cl_in;
        logic cu_in;
        logic b_in;
        logic a_in;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    localparam mode_t MODE_RESET = '{
        b_strobed: 1'b0,
        a_strobed: 1'b0,
        cl_in:     1'b1,
        cu_in:     1'b1,
        b_in:      1'b1,
        a_in:      1'b1
    };

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             val;
    } bitop_t;

    // Lane offsets inside a group's three port-C handshake bits
    localparam int HS_IRQ  = 0;
    localparam int HS_STB  = 1;
    localparam int HS_FLAG = 2;

    // Group 0 is port A, group 1 is port B
    function automatic int grp_base(input int g);
        return (g == 0) ? 3 : 0;
    endfunction

    function automatic logic grp_in(input mode_t m, input int g);
        return (g == 0) ? m.a_in : m.b_in;
    endfunction

    function automatic logic grp_strobed(input mode_t m, input int g);
        return (g == 0) ? m.a_strobed : m.b_strobed;
    endfunction

    function automatic bitop_t decode_bitop(input logic [BUS_W-1:0] w);
        return bitop_t'(w[IDX_W:0]);
    endfunction

    function automatic logic [BUS_W-1:0] mode_readback(input mode_t m);
        return {1'b1, {(BUS_W-1-MODE_W){1'b0}}, m};
    endfunction

endpackage

// File: rtl/par_io_cfg.sv
module par_io_cfg
    import par_io_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_ctl,
    input  logic [BUS_W-1:0] wdata,
    output mode_t            mode,
    output logic             mode_load,
    output logic             bit_op,
    output bitop_t           bop
);

    assign mode_load = wr_ctl && wdata[KIND_BIT];
    assign bit_op    = wr_ctl && !wdata[KIND_BIT];
    assign bop       = decode_bitop(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= MODE_RESET;
        end else if (mode_load) begin
            mode <= mode_t'(wdata[MODE_W-1:0]);
        end
    end

    // R10: single-bit command never disturbs the configuration
    assert_mode_kept_R10: assert property (@(posedge clk) disable iff (rst)
        bit_op |=> $stable(mode));

    // R2: configuration word lands in the register
    assert_mode_load_R2: assert property (@(posedge clk) disable iff (rst)
        mode_load |=> (mode == mode_t'($past(wdata[MODE_W-1:0]))));

endmodule

// File: rtl/par_io_group.sv
module par_io_group
    import par_io_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              strobed,
    input  logic              dir_in,
    input  logic              clr,
    input  logic              wr_port,
    input  logic              rd_port,
    input  logic [PORT_W-1:0] wdata,
    input  logic [PORT_W-1:0] pin_in,
    input  logic              hs_pin,
    output logic [PORT_W-1:0] out_q,
    output logic [PORT_W-1:0] rd_val,
    output logic              oe,
    output logic              irq,
    output logic              flag_pin
);

    logic [PORT_W-1:0] in_q;
    logic              full_q;
    logic              irq_q;
    logic              prev_q;
    logic              edge_seen;
    logic              hs_in_mode;
    logic              hs_out_mode;

    assign edge_seen   = prev_q && !hs_pin;
    assign hs_in_mode  = strobed && dir_in;
    assign hs_out_mode = strobed && !dir_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= '0;
            in_q   <= '0;
            full_q <= 1'b0;
            irq_q  <= 1'b0;
            prev_q <= 1'b1;
        end else begin
            prev_q <= hs_pin;
            if (clr) begin
                out_q  <= '0;
                full_q <= 1'b0;
                irq_q  <= 1'b0;
            end else begin
                if (wr_port) begin
                    out_q <= wdata;
                end
                if (hs_in_mode) begin
                    if (edge_seen) begin
                        in_q   <= pin_in;
                        full_q <= 1'b1;
                        irq_q  <= 1'b1;
                    end else if (rd_port) begin
                        full_q <= 1'b0;
                        irq_q  <= 1'b0;
                    end
                end else if (hs_out_mode) begin
                    if (wr_port) begin
                        full_q <= 1'b1;
                        irq_q  <= 1'b0;
                    end else if (edge_seen) begin
                        full_q <= 1'b0;
                        irq_q  <= 1'b1;
                    end
                end
            end
        end
    end

    assign oe       = !dir_in;
    assign irq      = irq_q;
    assign flag_pin = dir_in ? full_q : !full_q;

    always_comb begin
        if (hs_in_mode) begin
            rd_val = in_q;
        end else if (dir_in) begin
            rd_val = pin_in;
        end else begin
            rd_val = out_q;
        end
    end

    // R7: strobe falling edge raises flag and interrupt
    assert_strobe_sets_R7: assert property (@(posedge clk) disable iff (rst)
        (hs_in_mode && prev_q && !hs_pin && !clr) |=> (full_q && irq_q));

    // R7: a read without a new strobe clears the flag
    assert_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (hs_in_mode && rd_port && !(prev_q && !hs_pin) && !clr) |=> (!full_q && !irq_q));

    // R8: a write marks the output buffer full and drops the interrupt
    assert_write_sets_R8: assert property (@(posedge clk) disable iff (rst)
        (hs_out_mode && wr_port && !clr) |=> (full_q && !irq_q));

    // R8: acknowledge empties the buffer and interrupts
    assert_ack_R8: assert property (@(posedge clk) disable iff (rst)
        (hs_out_mode && prev_q && !hs_pin && !wr_port && !clr) |=> (!full_q && irq_q));

    // R2: configuration write clears latch and flags
    assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
        clr |=> (out_q == '0 && !full_q && !irq_q));

endmodule

// File: rtl/par_io_portc.sv
module par_io_portc
    import par_io_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             wr_port,
    input  logic [C_W-1:0]   wdata,
    input  logic             bit_op,
    input  bitop_t           bop,
    input  mode_t            mode,
    input  logic [N_GRP-1:0] irq,
    input  logic [N_GRP-1:0] flag,
    input  logic [C_W-1:0]   pin_in,
    output logic [C_W-1:0]   pin_out,
    output logic [C_W-1:0]   pin_oe,
    output logic [C_W-1:0]   rd_val
);

    logic [C_W-1:0] c_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q <= '0;
        end else if (clr) begin
            c_q <= '0;
        end else if (wr_port) begin
            c_q <= wdata;
        end else if (bit_op) begin
            c_q[bop.idx] <= bop.val;
        end
    end

    always_comb begin
        for (int i = 0; i < C_W; i++) begin
            pin_out[i] = c_q[i];
            pin_oe[i]  = (i < HALF_W) ? !mode.cl_in : !mode.cu_in;
        end
        for (int g = 0; g < N_GRP; g++) begin
            if (grp_strobed(mode, g)) begin
                pin_out[grp_base(g) + HS_IRQ]  = irq[g];
                pin_oe[grp_base(g) + HS_IRQ]   = 1'b1;
                pin_oe[grp_base(g) + HS_STB]   = 1'b0;
                pin_out[grp_base(g) + HS_FLAG] = flag[g];
                pin_oe[grp_base(g) + HS_FLAG]  = 1'b1;
            end
        end
    end

    assign rd_val = (pin_oe & pin_out) | (~pin_oe & pin_in);

    // R5: only the addressed bit may change
    assert_single_bit_R5: assert property (@(posedge clk) disable iff (rst)
        (bit_op && !clr && !wr_port) |=>
            (((c_q ^ $past(c_q)) & ~({{(C_W-1){1'b0}}, 1'b1} << $past(bop.idx))) == '0));

    // R5: addressed bit takes the commanded value
    assert_bit_value_R5: assert property (@(posedge clk) disable iff (rst)
        (bit_op && !clr && !wr_port) |=> (c_q[$past(bop.idx)] == $past(bop.val)));

    // R2: configuration write clears the port-C latch
    assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
        clr |=> (c_q == '0));

endmodule

// File: rtl/par_io_hub.sv
module par_io_hub
    import par_io_pkg::*;
(
    input  logic [0:0]        clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [PORT_W-1:0] pa_in,
    output logic [PORT_W-1:0] pa_out,
    output logic              pa_oe,
    input  logic [PORT_W-1:0] pb_in,
    output logic [PORT_W-1:0] pb_out,
    output logic              pb_oe,
    input  logic [C_W-1:0]    pc_in,
    output logic [C_W-1:0]    pc_out,
    output logic [C_W-1:0]    pc_oe
);

    reg_sel_e sel_e;
    mode_t    mode;
    logic     mode_load;
    logic     bit_op;
    bitop_t   bop;
    logic     wr_ctl;
    logic     wr_c;

    logic [N_GRP-1:0][PORT_W-1:0] grp_pin;
    logic [N_GRP-1:0][PORT_W-1:0] grp_out;
    logic [N_GRP-1:0][PORT_W-1:0] grp_rd;
    logic [N_GRP-1:0]             grp_oe;
    logic [N_GRP-1:0]             grp_irq;
    logic [N_GRP-1:0]             grp_flag;
    logic [N_GRP-1:0]             grp_wr;
    logic [N_GRP-1:0]             grp_rdsel;
    logic [C_W-1:0]               c_rd;

    assign sel_e  = reg_sel_e'(bus_sel);
    assign wr_ctl = bus_wr && (sel_e == SEL_CTL);
    assign wr_c   = bus_wr && (sel_e == SEL_C);

    assign grp_pin[0]   = pa_in;
    assign grp_pin[1]   = pb_in;
    assign grp_wr[0]    = bus_wr && (sel_e == SEL_A);
    assign grp_wr[1]    = bus_wr && (sel_e == SEL_B);
    assign grp_rdsel[0] = bus_rd && (sel_e == SEL_A);
    assign grp_rdsel[1] = bus_rd && (sel_e == SEL_B);

    par_io_cfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_ctl    (wr_ctl),
        .wdata     (bus_wdata),
        .mode      (mode),
        .mode_load (mode_load),
        .bit_op    (bit_op),
        .bop       (bop)
    );

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        localparam int BASE = grp_base(g);
        par_io_group u_grp (
            .clk      (clk),
            .rst      (rst),
            .strobed  (grp_strobed(mode, g)),
            .dir_in   (grp_in(mode, g)),
            .clr      (mode_load),
            .wr_port  (grp_wr[g]),
            .rd_port  (grp_rdsel[g]),
            .wdata    (bus_wdata),
            .pin_in   (grp_pin[g]),
            .hs_pin   (pc_in[BASE + HS_STB]),
            .out_q    (grp_out[g]),
            .rd_val   (grp_rd[g]),
            .oe       (grp_oe[g]),
            .irq      (grp_irq[g]),
            .flag_pin (grp_flag[g])
        );
    end

    par_io_portc u_portc (
        .clk     (clk),
        .rst     (rst),
        .clr     (mode_load),
        .wr_port (wr_c),
        .wdata   (bus_wdata),
        .bit_op  (bit_op),
        .bop     (bop),
        .mode    (mode),
        .irq     (grp_irq),
        .flag    (grp_flag),
        .pin_in  (pc_in),
        .pin_out (pc_out),
        .pin_oe  (pc_oe),
        .rd_val  (c_rd)
    );

    assign pa_out = grp_out[0];
    assign pa_oe  = grp_oe[0];
    assign pb_out = grp_out[1];
    assign pb_oe  = grp_oe[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            unique case (sel_e)
                SEL_A:   bus_rdata <= grp_rd[0];
                SEL_B:   bus_rdata <= grp_rd[1];
                SEL_C:   bus_rdata <= c_rd;
                default: bus_rdata <= mode_readback(mode);
            endcase
        end
    end

    // R4: basic input read returns the pins seen in the read cycle
    assert_live_read_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && sel_e == SEL_A && mode.a_in && !mode.a_strobed) |=> (bus_rdata == $past(pa_in)));

    // R9: strobe/acknowledge lanes are never driven in strobed mode
    assert_strobe_lane_R9: assert property (@(posedge clk) disable iff (rst)
        mode.a_strobed |-> !pc_oe[4]);

endmodule

// File: tb/par_io_hub_test.sv
`timescale 1ns/1ps
module par_io_hub_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_sel = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pa_in = 8'h00;
    logic [7:0] pa_out;
    logic       pa_oe;
    logic [7:0] pb_in = 8'h00;
    logic [7:0] pb_out;
    logic       pb_oe;
    logic [7:0] pc_in = 8'hFF;
    logic [7:0] pc_out;
    logic [7:0] pc_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    par_io_hub uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    // Reference model: md bit0 A in, 1 B in, 2 C upper in, 3 C lower in, 4 A strobed, 5 B strobed
    logic [5:0] md;
    logic [7:0] la, lb, lc, ia, ib, m_rd;
    logic       fa, fb, qa, qb, pva, pvb;

    function automatic logic [7:0] exp_pc_out();
        logic [7:0] o;
        o = lc;
        if (md[4]) begin o[3] = qa; o[5] = md[0] ? fa : !fa; end
        if (md[5]) begin o[0] = qb; o[2] = md[1] ? fb : !fb; end
        return o;
    endfunction

    function automatic logic [7:0] exp_pc_oe();
        logic [7:0] e;
        e = {{4{!md[2]}}, {4{!md[3]}}};
        if (md[4]) begin e[3] = 1'b1; e[4] = 1'b0; e[5] = 1'b1; end
        if (md[5]) begin e[0] = 1'b1; e[1] = 1'b0; e[2] = 1'b1; end
        return e;
    endfunction

    function automatic logic [7:0] model_read(input logic [1:0] s);
        logic [7:0] e;
        case (s)
            2'd0: return (md[4] && md[0]) ? ia : (md[0] ? pa_in : la);
            2'd1: return (md[5] && md[1]) ? ib : (md[1] ? pb_in : lb);
            2'd2: begin
                e = exp_pc_oe();
                return (e & exp_pc_out()) | (~e & pc_in);
            end
            default: return {2'b10, md};
        endcase
    endfunction

    always @(posedge clk) begin
        logic fall_a, fall_b;
        if (rst) begin
            md = 6'b001111; la = 0; lb = 0; lc = 0; ia = 0; ib = 0; m_rd = 0;
            fa = 0; fb = 0; qa = 0; qb = 0; pva = 1; pvb = 1;
        end else begin
            fall_a = pva && !pc_in[4];
            fall_b = pvb && !pc_in[1];
            if (bus_rd) m_rd = model_read(bus_sel);
            if (bus_wr && bus_sel == 2'd3 && bus_wdata[7]) begin
                md = bus_wdata[5:0]; la = 0; lb = 0; lc = 0;
                fa = 0; fb = 0; qa = 0; qb = 0;
            end else begin
                if (md[4] && md[0]) begin
                    if (fall_a) begin ia = pa_in; fa = 1; qa = 1; end
                    else if (bus_rd && bus_sel == 2'd0) begin fa = 0; qa = 0; end
                end else if (md[4]) begin
                    if (bus_wr && bus_sel == 2'd0) begin fa = 1; qa = 0; end
                    else if (fall_a) begin fa = 0; qa = 1; end
                end
                if (md[5] && md[1]) begin
                    if (fall_b) begin ib = pb_in; fb = 1; qb = 1; end
                    else if (bus_rd && bus_sel == 2'd1) begin fb = 0; qb = 0; end
                end else if (md[5]) begin
                    if (bus_wr && bus_sel == 2'd1) begin fb = 1; qb = 0; end
                    else if (fall_b) begin fb = 0; qb = 1; end
                end
                if (bus_wr && bus_sel == 2'd0) la = bus_wdata;
                if (bus_wr && bus_sel == 2'd1) lb = bus_wdata;
                if (bus_wr && bus_sel == 2'd2) lc = bus_wdata;
                if (bus_wr && bus_sel == 2'd3) lc[bus_wdata[3:1]] = bus_wdata[0];
            end
            pva = pc_in[4];
            pvb = pc_in[1];
        end
    end

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R3 pa_out", pa_out, la);
            check("R3 pa_oe", {7'd0, pa_oe}, {7'd0, !md[0]});
            check("R3 pb_out", pb_out, lb);
            check("R3 pb_oe", {7'd0, pb_oe}, {7'd0, !md[1]});
            check("R9 pc_out", pc_out, exp_pc_out());
            check("R9 pc_oe", pc_oe, exp_pc_oe());
            check("R4 bus_rdata", bus_rdata, m_rd);
        end
    end

    task automatic bus_write(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        bus_sel = s; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] s, output logic [7:0] d);
        @(negedge clk);
        bus_sel = s; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse_c(input int bit_no);
        @(negedge clk);
        pc_in[bit_no] = 1'b0;
        @(negedge clk);
        pc_in[bit_no] = 1'b1;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_read(2'd3, r);
        check("R1 ctl readback", r, 8'h8F);
        check("R1 pc_oe", pc_oe, 8'h00);
        check("R1 pa_oe", {7'd0, pa_oe}, 8'h00);

        // R2 all outputs, basic
        bus_write(2'd3, 8'h80);
        check("R2 pc_oe", pc_oe, 8'hFF);
        check("R2 pa_oe", {7'd0, pa_oe}, 8'h01);
        bus_write(2'd0, 8'h5A);
        check("R3 pa_out", pa_out, 8'h5A);
        bus_read(2'd0, r);
        check("R3 read latch", r, 8'h5A);
        bus_write(2'd2, 8'h3C);
        bus_write(2'd3, 8'h0D);
        check("R5 set bit 6", pc_out, 8'h7C);
        bus_write(2'd3, 8'h04);
        check("R5 clear bit 2", pc_out, 8'h78);
        check("R10 ctl after bit op", model_read(2'd3), 8'h80);
        bus_read(2'd3, r);
        check("R10 ctl readback", r, 8'h80);

        // R2 re-load clears latches
        bus_write(2'd3, 8'h80);
        check("R2 pa cleared", pa_out, 8'h00);
        check("R2 pc cleared", pc_out, 8'h00);

        // R4 / R6: A and C upper input, B and C lower output
        bus_write(2'd3, 8'h85);
        pa_in = 8'h11;
        bus_read(2'd0, r);
        check("R4 first read", r, 8'h11);
        pa_in = 8'h22;
        bus_read(2'd0, r);
        check("R4 live pins", r, 8'h22);
        bus_write(2'd0, 8'hFF);
        check("R3 input not driven", {7'd0, pa_oe}, 8'h00);
        pc_in = 8'hA5;
        bus_write(2'd2, 8'h0F);
        check("R6 pc_oe halves", pc_oe, 8'h0F);
        bus_read(2'd2, r);
        check("R6 mixed read", r, 8'hAF);

        // R7 strobed input on A, everything else output
        pc_in = 8'hFF;
        bus_write(2'd3, 8'h91);
        check("R9 A lanes oe", pc_oe, 8'hEF);
        pa_in = 8'hC3;
        pulse_c(4);
        check("R7 flag set", {7'd0, pc_out[5]}, 8'h01);
        check("R7 irq set", {7'd0, pc_out[3]}, 8'h01);
        pa_in = 8'h00;
        bus_read(2'd0, r);
        check("R7 captured data", r, 8'hC3);
        check("R7 flag cleared", {7'd0, pc_out[5]}, 8'h00);
        check("R7 irq cleared", {7'd0, pc_out[3]}, 8'h00);

        // R8 strobed output on B, A basic input
        bus_write(2'd3, 8'hA1);
        check("R8 obf idle high", {7'd0, pc_out[2]}, 8'h01);
        check("R9 B lanes oe", pc_oe, 8'hFD);
        bus_write(2'd1, 8'h96);
        check("R8 data latched", pb_out, 8'h96);
        check("R8 obf active", {7'd0, pc_out[2]}, 8'h00);
        check("R8 irq low", {7'd0, pc_out[0]}, 8'h00);
        pulse_c(1);
        check("R8 ack obf", {7'd0, pc_out[2]}, 8'h01);
        check("R8 ack irq", {7'd0, pc_out[0]}, 8'h01);
        bus_write(2'd1, 8'h33);
        check("R8 rewrite drops irq", {7'd0, pc_out[0]}, 8'h00);

        // R9 bit command on a handshake lane does not reach the pin
        bus_write(2'd3, 8'h01);
        check("R9 lane kept", {7'd0, pc_out[0]}, 8'h00);
        bus_read(2'd3, r);
        check("R10 ctl readback", r, 8'hA1);

        repeat (2) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule